// File: doc/BRIEF.md
# Debug Comms Status Read Gate

This block decides what happens when software asks to read the debug-comms status register. A request carries the register's encoding fields. The block also takes the current privilege level (0 to 3), a halted-in-debug indication, implementation-option flags, and the trap controls held by levels 1, 2 and 3.

A request that hits the register encoding gets exactly one verdict one cycle later:
- undefined instruction;
- a trap to level 1, 2 or 3, always with exception class 0x18;
- a successful read, returning a 64-bit status word.

The status word carries the transmit-channel-full flag and the receive-channel-full flag. Every other bit of the word is zero. A request with any other encoding gets no response at all.

Inside the block, a two-state controller (`ST_IDLE`, `ST_RESP`) sequences the response. A combinational resolver applies the level-dependent priority chain. A small word former builds the read value. The transitions are:
- **ST_IDLE → ST_RESP** on a request that hits the encoding.
- **ST_RESP → ST_RESP** on a further hit, which gives back-to-back responses.
- **ST_RESP → ST_IDLE** when the cycle carries no hit.
- **ST_IDLE → ST_IDLE** when the cycle carries no hit.

Top module: `dccsr_status_gate`

## Requirements
- R1: A request with `req_valid`=1 and encoding op0=2, op1=3, CRn=0, CRm=1, op2=0 yields `rsp_valid`=1 on the following cycle. A request with any other encoding, or no request, yields `rsp_valid`=0 on the following cycle.
- R2: When `rsp_valid`=1, exactly one of `rsp_undef`, `rsp_trap`, `rsp_allow` is 1. When `rsp_valid`=0, all outputs are 0, including right after reset.
- R3: If `feat_base64`=0, a matching request is answered as undefined.
- R4: With the base feature present, `halted`=1 and `ign_dbg_traps`=1, the read is allowed at any level, whatever the trap controls are.
- R5: At level 0 the checks run in this priority order:
  1. level-3 fine-grained comms trap with `sd_undef_prio` gives undefined;
  2. level-3 debug-access trap with `sd_undef_prio` gives undefined;
  3. `l1_comms_trap` traps to level 1, or to level 2 when `l2_en`=1 and `l2_route_all`=1;
  4. level-2 fine-grained comms trap traps to level 2;
  5. `l2_route_all`, `l2_dbg_exc_trap` or `l2_dbg_acc_trap` traps to level 2;
  6. level-3 fine-grained comms trap, then level-3 debug-access trap, trap to level 3;
  7. otherwise the read is allowed.
- R6: Level 1 uses the level 0 order without the `l1_comms_trap` check. Its level-2 routing check considers only `l2_dbg_exc_trap` and `l2_dbg_acc_trap`, not `l2_route_all`.
- R7: Level 2 checks only the level-3 controls, in this order: the two `sd_undef_prio` undefined cases, then the fine-grained comms trap, then the debug-access trap.
- R8: At level 3 (base feature present) the read is always allowed.
- R9: A trap that would go to level 3 is reported as undefined instead when `sd_undef_now`=1.
- R10: Level-2 controls are ignored when `l2_en`=0. Level-3 controls are ignored when `l3_en`=0. Fine-grained controls are ignored when `feat_fgt`=0.
- R11: A trap reports `rsp_class`=0x18 and a target of 1, 2 or 3 in `rsp_target`. Any other verdict reports class 0 and target 0.
- R12: An allowed read returns `rx_full` (as sampled at the request) in bit 30 and `tx_full` in bit 29 of `rsp_data`, with all other bits 0. `rsp_data` is 0 for any verdict that is not an allowed read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle read request strobe |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| cur_level | input | 2 | Current privilege level 0..3 |
| feat_base64 | input | 1 | 64-bit execution feature present |
| halted | input | 1 | Core halted in debug |
| ign_dbg_traps | input | 1 | Option: ignore traps while halted |
| feat_fgt | input | 1 | Fine-grained trap feature present |
| l2_en | input | 1 | Level 2 enabled |
| l3_en | input | 1 | Level 3 present |
| l1_comms_trap | input | 1 | Level-1 comms trap control |
| l2_fg_comms_trap | input | 1 | Level-2 fine-grained comms trap |
| l2_route_all | input | 1 | Level-2 general trap routing |
| l2_dbg_exc_trap | input | 1 | Level-2 debug exception routing |
| l2_dbg_acc_trap | input | 1 | Level-2 debug access trap |
| l3_fg_comms_trap | input | 1 | Level-3 fine-grained comms trap |
| l3_dbg_acc_trap | input | 1 | Level-3 debug access trap |
| sd_undef_prio | input | 1 | Secure-debug undefined takes priority |
| sd_undef_now | input | 1 | Secure-debug undefined condition active |
| rx_full | input | 1 | Receive channel full flag |
| tx_full | input | 1 | Transmit channel full flag |
| rsp_valid | output | 1 | Response strobe |
| rsp_undef | output | 1 | Verdict: undefined |
| rsp_trap | output | 1 | Verdict: trap |
| rsp_allow | output | 1 | Verdict: read allowed |
| rsp_target | output | 2 | Trap target level |
| rsp_class | output | 6 | Syndrome exception class |
| rsp_data | output | 64 | Read value |

## Verification
The bench builds the block with its default parameters:
- 64-bit read word;
- flag positions 30 and 29;
- exception class 0x18;
- the single register encoding.

This puts every rung of the three level-dependent priority chains within reach of directed vectors and a few thousand random ones. The random vectors are biased toward a present base feature and a clear debug halt, so that the deep chains are exercised rather than short-circuited. Mismatched encodings are mixed in to test the silent no-response path. Back-to-back hits exercise the stay-in-response transition.

// File: rtl/dccsr_gate_pkg.sv
package dccsr_gate_pkg;

    typedef enum logic [1:0] {
        VK_NONE  = 2'd0,
        VK_UNDEF = 2'd1,
        VK_TRAP  = 2'd2,
        VK_ALLOW = 2'd3
    } verdict_kind_e;

    typedef struct packed {
        verdict_kind_e kind;
        logic [1:0]    target;
    } verdict_t;

    typedef struct packed {
        logic base64;
        logic halted;
        logic ign_dbg;
        logic fgt;
        logic l2_on;
        logic l3_on;
        logic l1_comms;
        logic l2_fg;
        logic l2_all;
        logic l2_dexc;
        logic l2_dacc;
        logic l3_fg;
        logic l3_dacc;
        logic sd_prio;
        logic sd_now;
    } trap_ctrl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } gate_state_e;

endpackage

// File: rtl/dccsr_enc_match.sv
module dccsr_enc_match #(
    parameter logic [1:0] OP0 = 2'd2,
    parameter logic [2:0] OP1 = 3'd3,
    parameter logic [3:0] CRN = 4'd0,
    parameter logic [3:0] CRM = 4'd1,
    parameter logic [2:0] OP2 = 3'd0
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);
    localparam int ENC_W = 16;
    localparam logic [ENC_W-1:0] KEY = {OP0, OP1, CRN, CRM, OP2};

    assign hit = ({op0, op1, crn, crm, op2} == KEY);
endmodule

// File: rtl/dccsr_trap_resolver.sv
module dccsr_trap_resolver
    import dccsr_gate_pkg::*;
(
    input  logic [1:0] level,
    input  trap_ctrl_t c,
    output verdict_t   v
);
    logic fg3, da3, fg2, pair2, all2;

    // Presence and feature gating of every control
    assign fg3   = c.l3_on & c.fgt & c.l3_fg;
    assign da3   = c.l3_on & c.l3_dacc;
    assign fg2   = c.l2_on & c.fgt & c.l2_fg;
    assign pair2 = c.l2_on & (c.l2_dexc | c.l2_dacc);
    assign all2  = c.l2_on & c.l2_all;

    function automatic verdict_t mk(input verdict_kind_e k, input logic [1:0] t);
        verdict_t r;
        r.kind   = k;
        r.target = t;
        return r;
    endfunction

    // Upper-level trap, demoted to undefined under the secure-debug condition
    function automatic verdict_t up3(input logic sd);
        return sd ? mk(VK_UNDEF, 2'd0) : mk(VK_TRAP, 2'd3);
    endfunction

    always_comb begin
        v = mk(VK_ALLOW, 2'd0);
        if (!c.base64) begin
            v = mk(VK_UNDEF, 2'd0);
        end else if (c.halted && c.ign_dbg) begin
            v = mk(VK_ALLOW, 2'd0);
        end else begin
            unique case (level)
                2'd0, 2'd1: begin
                    if (fg3 && c.sd_prio)
                        v = mk(VK_UNDEF, 2'd0);
                    else if (da3 && c.sd_prio)
                        v = mk(VK_UNDEF, 2'd0);
                    else if (level == 2'd0 && c.l1_comms)
                        v = mk(VK_TRAP, all2 ? 2'd2 : 2'd1);
                    else if (fg2)
                        v = mk(VK_TRAP, 2'd2);
                    else if (pair2 || (level == 2'd0 && all2))
                        v = mk(VK_TRAP, 2'd2);
                    else if (fg3 || da3)
                        v = up3(c.sd_now);
                end
                2'd2: begin
                    if ((fg3 || da3) && c.sd_prio)
                        v = mk(VK_UNDEF, 2'd0);
                    else if (fg3 || da3)
                        v = up3(c.sd_now);
                end
                2'd3: v = mk(VK_ALLOW, 2'd0);
                default: v = mk(VK_ALLOW, 2'd0);
            endcase
        end
    end
endmodule

// File: rtl/dccsr_word_former.sv
module dccsr_word_former #(
    parameter int DATA_W = 64,
    parameter int RX_POS = 30,
    parameter int TX_POS = 29
) (
    input  logic              rx,
    input  logic              tx,
    output logic [DATA_W-1:0] word
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i == RX_POS) begin : g_rx
            assign word[i] = rx;
        end else if (i == TX_POS) begin : g_tx
            assign word[i] = tx;
        end else begin : g_zero
            assign word[i] = 1'b0;
        end
    end
endmodule

// File: rtl/dccsr_status_gate.sv
module dccsr_status_gate
    import dccsr_gate_pkg::*;
#(
    parameter int          DATA_W = 64,
    parameter int          RX_POS = 30,
    parameter int          TX_POS = 29,
    parameter int          EC_W   = 6,
    parameter logic [5:0]  EC_VAL = 6'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op0,
    input  logic [2:0]        req_op1,
    input  logic [3:0]        req_crn,
    input  logic [3:0]        req_crm,
    input  logic [2:0]        req_op2,
    input  logic [1:0]        cur_level,
    input  logic              feat_base64,
    input  logic              halted,
    input  logic              ign_dbg_traps,
    input  logic              feat_fgt,
    input  logic              l2_en,
    input  logic              l3_en,
    input  logic              l1_comms_trap,
    input  logic              l2_fg_comms_trap,
    input  logic              l2_route_all,
    input  logic              l2_dbg_exc_trap,
    input  logic              l2_dbg_acc_trap,
    input  logic              l3_fg_comms_trap,
    input  logic              l3_dbg_acc_trap,
    input  logic              sd_undef_prio,
    input  logic              sd_undef_now,
    input  logic              rx_full,
    input  logic              tx_full,
    output logic              rsp_valid,
    output logic              rsp_undef,
    output logic              rsp_trap,
    output logic              rsp_allow,
    output logic [1:0]        rsp_target,
    output logic [EC_W-1:0]   rsp_class,
    output logic [DATA_W-1:0] rsp_data
);
    localparam logic [EC_W-1:0] CLASS_TRAP = EC_W'(EC_VAL);

    gate_state_e       state_q, state_d;
    logic              enc_hit, take;
    trap_ctrl_t        ctrl;
    verdict_t          verdict;
    logic [DATA_W-1:0] status_word;

    dccsr_enc_match u_match (
        .op0 (req_op0),
        .op1 (req_op1),
        .crn (req_crn),
        .crm (req_crm),
        .op2 (req_op2),
        .hit (enc_hit)
    );

    assign ctrl = '{
        base64:   feat_base64,
        halted:   halted,
        ign_dbg:  ign_dbg_traps,
        fgt:      feat_fgt,
        l2_on:    l2_en,
        l3_on:    l3_en,
        l1_comms: l1_comms_trap,
        l2_fg:    l2_fg_comms_trap,
        l2_all:   l2_route_all,
        l2_dexc:  l2_dbg_exc_trap,
        l2_dacc:  l2_dbg_acc_trap,
        l3_fg:    l3_fg_comms_trap,
        l3_dacc:  l3_dbg_acc_trap,
        sd_prio:  sd_undef_prio,
        sd_now:   sd_undef_now
    };

    dccsr_trap_resolver u_resolve (
        .level (cur_level),
        .c     (ctrl),
        .v     (verdict)
    );

    dccsr_word_former #(
        .DATA_W (DATA_W),
        .RX_POS (RX_POS),
        .TX_POS (TX_POS)
    ) u_word (
        .rx   (rx_full),
        .tx   (tx_full),
        .word (status_word)
    );

    assign take = req_valid & enc_hit;

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = take ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = take ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered verdict outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_undef  <= 1'b0;
            rsp_trap   <= 1'b0;
            rsp_allow  <= 1'b0;
            rsp_target <= 2'd0;
            rsp_class  <= '0;
            rsp_data   <= '0;
        end else if (take) begin
            rsp_undef  <= (verdict.kind == VK_UNDEF);
            rsp_trap   <= (verdict.kind == VK_TRAP);
            rsp_allow  <= (verdict.kind == VK_ALLOW);
            rsp_target <= (verdict.kind == VK_TRAP) ? verdict.target : 2'd0;
            rsp_class  <= (verdict.kind == VK_TRAP) ? CLASS_TRAP : '0;
            rsp_data   <= (verdict.kind == VK_ALLOW) ? status_word : '0;
        end else begin
            rsp_undef  <= 1'b0;
            rsp_trap   <= 1'b0;
            rsp_allow  <= 1'b0;
            rsp_target <= 2'd0;
            rsp_class  <= '0;
            rsp_data   <= '0;
        end
    end

    assign rsp_valid = (state_q == ST_RESP);
endmodule

// File: rtl/dccsr_gate_chk.sv
module dccsr_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [1:0]  req_op0,
    input logic [2:0]  req_op1,
    input logic [3:0]  req_crn,
    input logic [3:0]  req_crm,
    input logic [2:0]  req_op2,
    input logic [1:0]  cur_level,
    input logic        feat_base64,
    input logic        halted,
    input logic        ign_dbg_traps,
    input logic        rsp_valid,
    input logic        rsp_undef,
    input logic        rsp_trap,
    input logic        rsp_allow,
    input logic [1:0]  rsp_target,
    input logic [5:0]  rsp_class,
    input logic [63:0] rsp_data
);
    localparam logic [63:0] FLAG_MASK = (64'd1 << 30) | (64'd1 << 29);

    logic hit;
    assign hit = req_valid && req_op0 == 2'd2 && req_op1 == 3'd3 &&
                 req_crn == 4'd0 && req_crm == 4'd1 && req_op2 == 3'd0;

    // R1
    resp_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> rsp_valid);
    // R1
    no_resp_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !rsp_valid);
    // R2
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_undef, rsp_trap, rsp_allow}) == 1);
    // R2
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_undef && !rsp_trap && !rsp_allow && rsp_data == 64'd0);
    // R3
    no_base_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !feat_base64) |=> rsp_undef);
    // R4
    halt_ignore_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && feat_base64 && halted && ign_dbg_traps) |=> rsp_allow);
    // R8
    top_level_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && feat_base64 && cur_level == 2'd3) |=> rsp_allow);
    // R11
    trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> rsp_class == 6'h18 && rsp_target != 2'd0);
    // R11
    nontrap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_trap |-> rsp_class == 6'h0 && rsp_target == 2'd0);
    // R12
    data_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_allow |-> (rsp_data & ~FLAG_MASK) == 64'd0);
endmodule

bind dccsr_status_gate dccsr_gate_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_op0       (req_op0),
    .req_op1       (req_op1),
    .req_crn       (req_crn),
    .req_crm       (req_crm),
    .req_op2       (req_op2),
    .cur_level     (cur_level),
    .feat_base64   (feat_base64),
    .halted        (halted),
    .ign_dbg_traps (ign_dbg_traps),
    .rsp_valid     (rsp_valid),
    .rsp_undef     (rsp_undef),
    .rsp_trap      (rsp_trap),
    .rsp_allow     (rsp_allow),
    .rsp_target    (rsp_target),
    .rsp_class     (rsp_class),
    .rsp_data      (rsp_data)
);

// File: tb/sim_dccsr_status_gate.sv
`timescale 1ns/1ps
module sim_dccsr_status_gate;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        req_valid = 1'b0;
    logic [1:0]  req_op0 = 2'd0;
    logic [2:0]  req_op1 = 3'd0;
    logic [3:0]  req_crn = 4'd0, req_crm = 4'd0;
    logic [2:0]  req_op2 = 3'd0;
    logic [1:0]  cur_level = 2'd0;
    // bit order: 0 base64, 1 halted, 2 ign, 3 fgt, 4 l2_en, 5 l3_en, 6 l1_comms,
    // 7 l2_fg, 8 l2_all, 9 l2_dexc, 10 l2_dacc, 11 l3_fg, 12 l3_dacc,
    // 13 sd_prio, 14 sd_now, 15 rx, 16 tx
    logic [16:0] cv = '0;

    logic        rsp_valid, rsp_undef, rsp_trap, rsp_allow;
    logic [1:0]  rsp_target;
    logic [5:0]  rsp_class;
    logic [63:0] rsp_data;

    dccsr_status_gate u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn),
        .req_crm(req_crm), .req_op2(req_op2), .cur_level(cur_level),
        .feat_base64(cv[0]), .halted(cv[1]), .ign_dbg_traps(cv[2]),
        .feat_fgt(cv[3]), .l2_en(cv[4]), .l3_en(cv[5]),
        .l1_comms_trap(cv[6]), .l2_fg_comms_trap(cv[7]), .l2_route_all(cv[8]),
        .l2_dbg_exc_trap(cv[9]), .l2_dbg_acc_trap(cv[10]),
        .l3_fg_comms_trap(cv[11]), .l3_dbg_acc_trap(cv[12]),
        .sd_undef_prio(cv[13]), .sd_undef_now(cv[14]),
        .rx_full(cv[15]), .tx_full(cv[16]),
        .rsp_valid(rsp_valid), .rsp_undef(rsp_undef), .rsp_trap(rsp_trap),
        .rsp_allow(rsp_allow), .rsp_target(rsp_target), .rsp_class(rsp_class),
        .rsp_data(rsp_data)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // expectation: kind 0 none, 1 undef, 2 trap, 3 allow
    typedef struct { int kind; int tgt; logic [63:0] data; string tag; } exp_t;
    exp_t pend[$];

    function automatic exp_t predict(logic v, logic m, int lvl, logic [16:0] b);
        exp_t e;
        bit u3fg, u3da, u2fg, u2pair, u2all;
        e.kind = 0; e.tgt = 0; e.data = 64'd0; e.tag = "R1";
        if (!(v && m)) return e;
        u3fg   = b[5] && b[3] && b[11];
        u3da   = b[5] && b[12];
        u2fg   = b[4] && b[3] && b[7];
        u2pair = b[4] && (b[9] || b[10]);
        u2all  = b[4] && b[8];
        e.kind = 3;
        if (!b[0]) begin e.kind = 1; e.tag = "R3"; return e; end
        if (b[1] && b[2]) e.tag = "R4";
        else if (lvl == 3) e.tag = "R8";
        else begin
            e.tag = (lvl == 0) ? "R5" : (lvl == 1) ? "R6" : "R7";
            if (b[13] && (u3fg || u3da)) e.kind = 1;
            else if (lvl == 0 && b[6]) begin e.kind = 2; e.tgt = u2all ? 2 : 1; e.tag = "R10"; end
            else if (lvl < 2 && (u2fg || u2pair || (lvl == 0 && u2all))) begin e.kind = 2; e.tgt = 2; end
            else if (u3fg || u3da) begin
                if (b[14]) begin e.kind = 1; e.tag = "R9"; end
                else begin e.kind = 2; e.tgt = 3; end
            end
        end
        if (e.kind == 3) e.data = (64'(b[15]) << 30) | (64'(b[16]) << 29);
        return e;
    endfunction

    task automatic compare(exp_t e);
        int ak, cnt;
        int et;
        cnt = int'(rsp_undef) + int'(rsp_trap) + int'(rsp_allow);
        ak = rsp_undef ? 1 : rsp_trap ? 2 : rsp_allow ? 3 : 0;
        et = (e.kind == 2) ? 6'h18 : 0;
        n_vec++;
        if (rsp_valid !== (e.kind != 0) || cnt > 1 || ak != e.kind ||
            int'(rsp_target) != e.tgt || int'(rsp_class) != et ||
            rsp_data !== e.data) begin
            n_bad++;
            $display("FAIL %s: got v=%0b kind=%0d tgt=%0d cls=%0h data=%h exp v=%0b kind=%0d tgt=%0d cls=%0h data=%h",
                     e.tag, rsp_valid, ak, rsp_target, rsp_class, rsp_data,
                     e.kind != 0, e.kind, e.tgt, et, e.data);
        end
    endtask

    // Drive one request on the current negedge and queue its expectation
    task automatic step(logic v, logic m, int lvl, logic [16:0] b, string tag_over);
        exp_t e;
        @(negedge clk);
        if (pend.size() > 0) compare(pend.pop_front());
        req_valid = v;
        {req_op0, req_op1, req_crn, req_crm, req_op2} = m ?
            {2'd2, 3'd3, 4'd0, 4'd1, 3'd0} : {2'd2, 3'd3, 4'd0, 4'd1, 3'd1};
        cur_level = 2'(lvl);
        cv = b;
        e = predict(v, m, lvl, b);
        if (tag_over != "") e.tag = tag_over;
        pend.push_back(e);
    endtask

    initial begin
        exp_t z;
        z.kind = 0; z.tgt = 0; z.data = 64'd0; z.tag = "R2";
        repeat (3) @(negedge clk);
        compare(z);                                   // R2 reset state
        rst_n = 1'b1;
        // R1 non-matching encoding: silence
        step(1, 0, 0, 17'h0_0001, "R1");
        step(0, 1, 0, 17'h0_0001, "R1");
        // R3 base feature absent
        step(1, 1, 3, 17'h1_8000, "R3");
        // R4 halted with ignore option beats every trap
        step(1, 1, 0, 17'h1_FFFF & ~17'h0_4000 | 17'h0_0007, "R4");
        // R5 level 1 comms trap, routed to 2 then to 1
        step(1, 1, 0, 17'h0_0159, "R5");
        step(1, 1, 0, 17'h0_0049, "R10");
        // R6 level 1 ignores route-all bit
        step(1, 1, 1, 17'h0_0111, "R6");
        step(1, 1, 1, 17'h0_0211, "R6");
        // R7 level 2 level-3 debug access trap, then with priority undef
        step(1, 1, 2, 17'h0_1021, "R7");
        step(1, 1, 2, 17'h0_3021, "R7");
        // R9 secure-debug demotes level-3 trap
        step(1, 1, 2, 17'h0_5021, "R9");
        // R10 fine-grained ignored without feature, level 3 ignored when absent
        step(1, 1, 1, 17'h0_0891, "R10");
        step(1, 1, 0, 17'h0_1801, "R10");
        // R8 top level with all traps asserted
        step(1, 1, 3, 17'h1_7FF9, "R8");
        // R12 allowed read data
        step(1, 1, 3, 17'h0_8001, "R12");
        step(1, 1, 3, 17'h1_0001, "R12");
        // R11 trap class on level-2 fine-grained trap
        step(1, 1, 0, 17'h0_0099, "R11");
        // random mix, back-to-back
        for (int i = 0; i < 4000; i++) begin
            logic [16:0] b;
            b = 17'($urandom());
            if (($urandom() % 8) != 0) b[0] = 1'b1;
            if (($urandom() % 4) != 0) b[1] = 1'b0;
            step(($urandom() % 5) != 0, ($urandom() % 6) != 0,
                 int'($urandom() % 4), b, "");
        end
        step(0, 0, 0, 17'h0, "");
        @(negedge clk);
        if (pend.size() > 0) compare(pend.pop_front());
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule